// File: doc/BRIEF.md
# Countdown-Acknowledge Register Slave

This block is the slave end of a synchronous point-to-point link. The master gives each command as a single-cycle pulse on a read or write strobe, with the word address valid in that cycle and, for a write, the write data too. The slave captures these values. It then spends a fixed number of internal access cycles (parameter `ACCESS_CYC`, written N below) on a small register file of `2**ADDR_W` words, each `PORT_W` bits wide. Instead of a single acknowledge line, it drives a 2-bit countdown of the cycles left until the result. The master can therefore prepare its pipeline before the data arrives.

Read data is registered and kept on the bus until the next read completes, so the master may collect it late. The slave advertises read and write pipeline level 1 on two constant outputs. A new command is accepted in the very cycle the countdown reaches zero, while the previous result is still being presented. A command that arrives while the countdown is nonzero is discarded, and a correct master never sends one.

The controller has three states. `ST_IDLE` means the countdown is zero and the result is being presented. `ST_RD_WAIT` means a read is in progress and `ST_WR_WAIT` means a write is in progress. The transitions are:
- `ST_IDLE` to `ST_RD_WAIT` on an accepted read.
- `ST_IDLE` to `ST_WR_WAIT` on an accepted write, or on a write and a read together.
- `ST_RD_WAIT` to `ST_IDLE` on the last wait cycle, when the read word is loaded into the output register.
- `ST_WR_WAIT` to `ST_IDLE` on the last wait cycle, when the word is stored.
- Each wait state stays where it is while more than one cycle remains.

Top module: `rcnt_slave`

## Requirements
- R1: Address and write data are captured in the cycle a command is accepted. Values on `addr` and `wr_data` in later cycles of that transaction have no effect on its result.
- R2: For a command accepted in cycle C, `rdy_cnt` in cycle C+k equals min(N+1-k, 3) for k = 1..N+1. It therefore holds 3 while three or more cycles remain and reaches 0 in cycle C+N+1.
- R3: After reset, `rdy_cnt` is 0, `rd_data` is 0 and every storage word reads as 0. With no command, `rdy_cnt` stays 0.
- R4: A read's result appears on `rd_data` in cycle C+N+1. It is the addressed word zero-extended, so bits 31 down to `PORT_W` are 0. `rd_data` holds its value through writes and idle cycles until the next read completes.
- R5: A write stores bits `PORT_W-1`..0 of the captured write data at the addressed word, and the upper bits are discarded. The stored word becomes visible to any read accepted after the write's countdown reaches 0.
- R6: A command is accepted in any cycle where `rdy_cnt` is 0, including the first cycle of a just-finished result. The data being presented stays valid in that cycle, and the countdown restarts at min(N,3) in the next cycle.
- R7: A cycle with both `rd` and `wr` high is a write. `rd_data` is not updated by that transaction.
- R8: `rd_pipe_lvl` and `wr_pipe_lvl` are constant 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address, valid in the command cycle |
| wr_data | input | 32 | Write data, valid in the command cycle |
| rd | input | 1 | Single-cycle read command |
| wr | input | 1 | Single-cycle write command |
| rd_data | output | 32 | Registered read result, zero-extended |
| rdy_cnt | output | 2 | Saturating count of cycles to completion |
| rd_pipe_lvl | output | 2 | Constant read pipeline level |
| wr_pipe_lvl | output | 2 | Constant write pipeline level |

## Verification
The properties assume the master never strobes while `rdy_cnt` is nonzero. Under that assumption, every nonzero countdown belongs to one accepted command and must fall by one per cycle. The stimulus respects this rule by construction. Every command is driven either after the previous countdown has been observed at 0, or exactly in that zero cycle for the back-to-back case. Strobes are dropped one cycle after they are raised. The bench also scrambles the address and data lines while a transaction is pending, to show that only the captured values matter.

// File: rtl/rcnt_pkg.sv
package rcnt_pkg;

    localparam int BUS_W = 32;
    localparam logic [1:0] PIPE_LEVEL = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_WAIT = 2'd1,
        ST_WR_WAIT = 2'd2
    } rcnt_state_e;

    // Value shown on the countdown for a given number of remaining cycles.
    function automatic logic [1:0] sat_cnt(input int unsigned remaining);
        return (remaining > 3) ? 2'd3 : remaining[1:0];
    endfunction

endpackage

// File: rtl/rcnt_store.sv
module rcnt_store #(
    parameter int ADDR_W = 4,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [PORT_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [PORT_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH*PORT_W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [PORT_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (we && (waddr == ADDR_W'(g))) begin
                word_q <= wdata;
            end
        end

        assign flat[g*PORT_W +: PORT_W] = word_q;
    end

    assign rdata = flat[int'(raddr)*PORT_W +: PORT_W];

endmodule

// File: rtl/rcnt_fsm.sv
module rcnt_fsm
    import rcnt_pkg::*;
#(
    parameter int ACCESS_CYC = 3,
    parameter int ADDR_W     = 4,
    parameter int PORT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [PORT_W-1:0] wdata_q,
    output logic              done_rd,
    output logic              done_wr,
    output logic [1:0]        rdy_cnt
);
    localparam int RW = $clog2(ACCESS_CYC + 1);

    rcnt_state_e      state_q, state_d;
    logic [RW-1:0]    remaining_q;
    logic             accept;
    logic             last;

    assign accept = (state_q == ST_IDLE) && (rd || wr);
    assign last   = (remaining_q == RW'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr) begin
                    state_d = ST_WR_WAIT;
                end else if (rd) begin
                    state_d = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: if (last) state_d = ST_IDLE;
            ST_WR_WAIT: if (last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Command capture and remaining-cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remaining_q <= '0;
            addr_q      <= '0;
            wdata_q     <= '0;
        end else if (accept) begin
            remaining_q <= RW'(ACCESS_CYC);
            addr_q      <= addr;
            wdata_q     <= wdata;
        end else if (state_q != ST_IDLE) begin
            remaining_q <= remaining_q - RW'(1);
        end
    end

    // Outputs
    always_comb begin
        done_rd = 1'b0;
        done_wr = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_RD_WAIT: done_rd = last;
            ST_WR_WAIT: done_wr = last;
            default:    ;
        endcase
    end

    if (RW > 2) begin : g_sat
        assign rdy_cnt = (remaining_q > RW'(3)) ? 2'd3 : remaining_q[1:0];
    end else if (RW == 2) begin : g_fit
        assign rdy_cnt = remaining_q;
    end else begin : g_narrow
        assign rdy_cnt = {1'b0, remaining_q};
    end

endmodule

// File: rtl/rcnt_slave.sv
module rcnt_slave
    import rcnt_pkg::*;
#(
    parameter int ACCESS_CYC = 3,
    parameter int ADDR_W     = 4,
    parameter int PORT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    input  logic              rd,
    input  logic              wr,
    output logic [31:0]       rd_data,
    output logic [1:0]        rdy_cnt,
    output logic [1:0]        rd_pipe_lvl,
    output logic [1:0]        wr_pipe_lvl
);
    logic [ADDR_W-1:0] addr_q;
    logic [PORT_W-1:0] wdata_q;
    logic [PORT_W-1:0] word;
    logic              done_rd;
    logic              done_wr;
    logic [BUS_W-1:0]  rd_data_q;
    logic              unused_wdata;

    assign unused_wdata = ^wr_data;

    rcnt_fsm #(
        .ACCESS_CYC(ACCESS_CYC),
        .ADDR_W    (ADDR_W),
        .PORT_W    (PORT_W)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd     (rd),
        .wr     (wr),
        .addr   (addr),
        .wdata  (wr_data[PORT_W-1:0]),
        .addr_q (addr_q),
        .wdata_q(wdata_q),
        .done_rd(done_rd),
        .done_wr(done_wr),
        .rdy_cnt(rdy_cnt)
    );

    rcnt_store #(
        .ADDR_W(ADDR_W),
        .PORT_W(PORT_W)
    ) u_store (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (done_wr),
        .waddr(addr_q),
        .wdata(wdata_q),
        .raddr(addr_q),
        .rdata(word)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (done_rd) begin
            rd_data_q <= BUS_W'(word);
        end
    end

    assign rd_data     = rd_data_q;
    assign rd_pipe_lvl = PIPE_LEVEL;
    assign wr_pipe_lvl = PIPE_LEVEL;

endmodule

// File: rtl/rcnt_slave_chk.sv
module rcnt_slave_chk
    import rcnt_pkg::*;
#(
    parameter int ACCESS_CYC = 3,
    parameter int PORT_W     = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        rd,
    input logic        wr,
    input logic [1:0]  rdy_cnt,
    input logic [31:0] rd_data
);
    localparam logic [1:0]  FIRST    = sat_cnt(ACCESS_CYC);
    localparam logic [31:0] LOW_MASK = (PORT_W >= 32) ? 32'hFFFF_FFFF
                                                      : ((32'd1 << PORT_W) - 32'd1);

    assert_start_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_cnt == 2'd0 && (rd || wr)) |=> (rdy_cnt == FIRST));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_cnt == 2'd1 || rdy_cnt == 2'd2) |=> (rdy_cnt == $past(rdy_cnt) - 2'd1));

    assert_saturate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_cnt == 2'd3) |=> (rdy_cnt == 2'd3 || rdy_cnt == 2'd2));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_cnt == 2'd0 && !rd && !wr) |=> (rdy_cnt == 2'd0));

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_cnt != 2'd1) |=> $stable(rd_data));

    assert_zero_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data & ~LOW_MASK) == 32'd0));

endmodule

bind rcnt_slave rcnt_slave_chk #(
    .ACCESS_CYC(ACCESS_CYC),
    .PORT_W    (PORT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (rd),
    .wr     (wr),
    .rdy_cnt(rdy_cnt),
    .rd_data(rd_data)
);

// File: tb/sim_rcnt_slave.sv
module sim_rcnt_slave;
    localparam int N      = 5;
    localparam int ADDR_W = 3;
    localparam int PORT_W = 16;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wr_data = '0;
    logic              rd = 1'b0;
    logic              wr = 1'b0;
    logic [31:0]       rd_data;
    logic [1:0]        rdy_cnt;
    logic [1:0]        rd_pipe_lvl;
    logic [1:0]        wr_pipe_lvl;

    int checks = 0;
    int fails  = 0;
    logic [PORT_W-1:0] mdl [DEPTH];
    logic [31:0]       exp_rd = '0;
    bit                chained = 1'b0;

    always #10 clk = ~clk;

    rcnt_slave #(.ACCESS_CYC(N), .ADDR_W(ADDR_W), .PORT_W(PORT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .rd(rd), .wr(wr),
        .rd_data(rd_data), .rdy_cnt(rdy_cnt),
        .rd_pipe_lvl(rd_pipe_lvl), .wr_pipe_lvl(wr_pipe_lvl)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [31:0] pat(input int a, input int s);
        return 32'hDEAD_0000 ^ (32'(a) * 32'h0001_0321) ^ (32'(s) * 32'h0104_2081);
    endfunction

    // Called at a falling edge where rdy_cnt is 0; returns at the falling edge
    // of the cycle in which the countdown is back at 0.
    task automatic issue(input bit do_rd, input bit do_wr, input int a, input logic [31:0] d);
        rd = do_rd; wr = do_wr; addr = ADDR_W'(a); wr_data = d;
        if (chained) check("R6 presented data in restart cycle", rd_data, exp_rd);
        for (int k = 1; k <= N + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                rd = 1'b0; wr = 1'b0;
                addr = ~ADDR_W'(a);           // R1: scramble after capture
                wr_data = ~d;
                if (chained) check("R6 countdown restart", 32'(rdy_cnt), 32'((N > 3) ? 3 : N));
            end
            if (k == N + 1) begin
                if (do_wr) mdl[a] = d[PORT_W-1:0];
                else if (do_rd) exp_rd = 32'(mdl[a]);
            end
            check("R2 countdown", 32'(rdy_cnt), 32'(((N + 1 - k) > 3) ? 3 : (N + 1 - k)));
            check(do_wr ? "R7 R5 data held during write" : "R4 R1 read data", rd_data, exp_rd);
        end
    endtask

    task automatic gap(input int n);
        chained = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R3 idle countdown", 32'(rdy_cnt), 32'd0);
            check("R4 idle hold", rd_data, exp_rd);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        check("R3 reset countdown", 32'(rdy_cnt), 32'd0);
        check("R3 reset data", rd_data, 32'd0);
        check("R8 read level", 32'(rd_pipe_lvl), 32'd1);
        check("R8 write level", 32'(wr_pipe_lvl), 32'd1);
        rst_n = 1'b1;
        gap(2);

        // R3: fresh storage reads as zero
        for (int a = 0; a < DEPTH; a++) begin
            issue(1'b1, 1'b0, a, 32'hFFFF_FFFF);
            gap(1);
        end

        // R5 R6: back-to-back writes, then back-to-back reads
        for (int a = 0; a < DEPTH; a++) begin
            issue(1'b0, 1'b1, a, pat(a, 1));
            chained = 1'b1;
        end
        for (int a = 0; a < DEPTH; a++) begin
            issue(1'b1, 1'b0, a, 32'h0);
            check("R5 upper write bits dropped", rd_data, {16'h0, pat(a, 1)[15:0]});
        end
        gap(4);

        // R7: read and write together act as a write
        issue(1'b1, 1'b1, 2, 32'h1234_ABCD);
        chained = 1'b1;
        issue(1'b1, 1'b0, 2, 32'h0);
        check("R7 combined strobe wrote", rd_data, 32'h0000_ABCD);
        gap(3);

        // R4 R5 R6: reverse-order write then chained read of same word
        for (int a = DEPTH - 1; a >= 0; a--) begin
            issue(1'b0, 1'b1, a, pat(a, 7));
            chained = 1'b1;
            issue(1'b1, 1'b0, a, 32'h0);
            check("R4 zero-extended result", rd_data, 32'(pat(a, 7)[15:0]));
            gap(a % 3);
        end
        gap(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule